// File: doc/BRIEF.md
# RTS/CTS Synchronous Serial Link Adapter

This block joins a frame source that speaks a clockless synchronous serial protocol to a byte-wide consumer inside the chip. The adapter is the clock master in both directions. It divides the system clock down to a serial clock with a 50% duty cycle. That clock drives the source's transmit-clock input, and its inverse is supplied as the partner's receive clock. When the source wants to send, it pulls its active-low request line low. The adapter then issues a one-cycle service pulse. If its byte queue has room, it answers with an active-low grant and shifts in bits, most significant bit first, until the source releases the request.

Each byte that completes is pushed into a first-word-fall-through FIFO, which the consumer drains with a read strobe. If the request ends in the middle of a byte, those bits are dropped and an incomplete-byte pulse is raised. In the other direction, the consumer hands over one byte at a time. The adapter shifts it out MSB first. The data line changes only as the serial clock rises, so it is steady when the partner's inverted clock rises. Framing and payload meaning belong to the layers around this block.

Top module: `rtscts_serial_adapter`

## Requirements
- R1: While reset is held and right after it, the grant line is high (not granted), `rd_valid` is 0, `svc_pulse` and `partial_pulse` are 0, `src_txc_out` is 0, `txd_out` is 1 and `tx_ready` is 1.
- R2: `src_txc_out` stays high for `half_period` system cycles and then low for `half_period` system cycles; a setting below 3 behaves as 3. `partner_rxc_out` is always the logical inverse of `src_txc_out`.
- R3: Each high-to-low transition of `rts_n_in` produces exactly one `svc_pulse` of one cycle, whether or not a grant follows.
- R4: `cts_n_out` goes low only while the synchronized request is low and the FIFO has room. While the request is high, activity on `rxd_in` leaves the grant high and the FIFO empty.
- R5: After the grant, bits are sampled on rising edges of `src_txc_out`, starting after the first falling edge. They are assembled MSB first, and the byte enters the FIFO on its eighth sampled bit.
- R6: Once `rts_n_in` returns high, `cts_n_out` returns high within 4 system cycles.
- R7: If the request ends with 1 to 7 bits of a byte collected, `partial_pulse` fires once and those bits never reach the FIFO. A transfer of whole bytes gives no pulse.
- R8: If the FIFO is full, a new request gets no grant until a read frees an entry. The grant follows within a few cycles of that read.
- R9: `rd_valid` is high while the FIFO holds data, and `rd_data` then shows the oldest byte. A cycle with `rd_en` high removes that byte, and bytes leave in arrival order.
- R10: A byte accepted with `tx_valid` and `tx_ready` both high appears on `txd_out` MSB first. Each bit is placed as `src_txc_out` rises and can be captured on rising edges of `partner_rxc_out`. `tx_ready` is low until all eight bits have left.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| half_period | input | DIV_W | Serial clock half period in system cycles |
| rts_n_in | input | 1 | Active-low send request from the source |
| rxd_in | input | 1 | Serial data from the source |
| src_txc_out | output | 1 | Generated serial clock to the source's transmit clock |
| cts_n_out | output | 1 | Active-low grant to the source |
| svc_pulse | output | 1 | One-cycle service event on a new request |
| partial_pulse | output | 1 | One-cycle flag for a dropped incomplete byte |
| rd_en | input | 1 | Pops the oldest FIFO byte |
| rd_data | output | 8 | Oldest FIFO byte |
| rd_valid | output | 1 | FIFO holds at least one byte |
| tx_valid | input | 1 | Byte offered for transmission |
| tx_data | input | 8 | Byte to transmit |
| tx_ready | output | 1 | Transmit shifter idle and able to accept |
| txd_out | output | 1 | Serial data to the partner |
| partner_rxc_out | output | 1 | Inverted serial clock for the partner's receiver |

## Verification
The bench runs transfers at several divider settings. A divider off by one gives phases of the wrong length, and a receiver that samples before the first falling edge after the grant shifts garbage into the first byte and misaligns every byte after it. Releasing the request three bits into a byte tests the incomplete-byte path. A design that keeps those bits would push a stray byte or corrupt the next one. Filling the queue and then raising a new request checks that the grant is held back and then given once one entry is read. A design that grants anyway would lose bytes or overwrite the queue.

// File: rtl/ssa_pkg.sv
`timescale 1ns/1ps
package ssa_pkg;
   localparam int BYTE_W = 8;
   typedef logic [BYTE_W-1:0] byte_t;
   typedef enum logic {RX_IDLE = 1'b0, RX_GRANT = 1'b1} rx_state_e;
endpackage

// File: rtl/ssa_sclk_gen.sv
`timescale 1ns/1ps
module ssa_sclk_gen #(
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [DIV_W-1:0] half_period,
   output logic             sclk,
   output logic             rise_tick,
   output logic             fall_tick
);
   logic [DIV_W-1:0] cnt;
   logic [DIV_W-1:0] lim_m1;
   logic             wrap;

   // settings below 3 are clamped so the receive synchronizer has time to settle
   assign lim_m1    = (half_period < DIV_W'(3)) ? DIV_W'(2) : half_period - DIV_W'(1);
   assign wrap      = (cnt >= lim_m1);
   assign rise_tick = wrap & ~sclk;
   assign fall_tick = wrap & sclk;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt  <= '0;
         sclk <= 1'b0;
      end else if (wrap) begin
         cnt  <= '0;
         sclk <= ~sclk;
      end else begin
         cnt  <= cnt + DIV_W'(1);
      end
   end

   // R2: a phase never ends before two system cycles have passed
   a_r2_min_phase : assert property (@(posedge clk) disable iff (!rst_n)
      (sclk != $past(sclk)) |=> $stable(sclk));
endmodule

// File: rtl/ssa_rx_link.sv
`timescale 1ns/1ps
module ssa_rx_link
   import ssa_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic  clk,
   input  logic  rst_n,
   input  logic  rts_n_in,
   input  logic  rxd_in,
   input  logic  rise_tick,
   input  logic  fall_tick,
   input  logic  fifo_full,
   output logic  cts_n,
   output logic  svc_pulse,
   output logic  partial_pulse,
   output logic  push,
   output byte_t push_data
);
   logic [1:0] stg [SYNC_STAGES];
   logic       rts_s, rxd_s, rts_prev, armed, grant;
   logic [2:0] bit_cnt;
   byte_t      shreg;
   rx_state_e  state;

   for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
      if (g == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) stg[g] <= 2'b11;
            else        stg[g] <= {rts_n_in, rxd_in};
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) stg[g] <= 2'b11;
            else        stg[g] <= stg[g-1];
      end
   end

   assign rts_s     = stg[SYNC_STAGES-1][1];
   assign rxd_s     = stg[SYNC_STAGES-1][0];
   assign grant     = (state == RX_GRANT);
   assign cts_n     = ~grant;
   assign push_data = shreg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rts_prev      <= 1'b1;
         svc_pulse     <= 1'b0;
         partial_pulse <= 1'b0;
         push          <= 1'b0;
         state         <= RX_IDLE;
         armed         <= 1'b0;
         bit_cnt       <= '0;
         shreg         <= '0;
      end else begin
         rts_prev      <= rts_s;
         svc_pulse     <= rts_prev & ~rts_s;
         partial_pulse <= 1'b0;
         push          <= 1'b0;
         case (state)
            RX_IDLE: begin
               armed   <= 1'b0;
               bit_cnt <= '0;
               if (!rts_s && !fifo_full) state <= RX_GRANT;
            end
            RX_GRANT: begin
               if (rts_s) begin
                  state         <= RX_IDLE;
                  partial_pulse <= (bit_cnt != 3'd0);
                  bit_cnt       <= '0;
                  armed         <= 1'b0;
               end else begin
                  if (fall_tick) armed <= 1'b1;
                  if (rise_tick && armed) begin
                     shreg   <= {shreg[BYTE_W-2:0], rxd_s};
                     bit_cnt <= bit_cnt + 3'd1;
                     if (bit_cnt == 3'd7) push <= ~fifo_full;
                  end
               end
            end
            default: state <= RX_IDLE;
         endcase
      end
   end

   // R4: a grant starts only from a pending request with queue space
   a_r4_grant_cond : assert property (@(posedge clk) disable iff (!rst_n)
      $rose(grant) |-> $past(!rts_s && !fifo_full));
   // R6: a released request ends the grant on the next cycle
   a_r6_release : assert property (@(posedge clk) disable iff (!rst_n)
      (grant && rts_s) |=> !grant);
   // R3: the service event lasts one cycle
   a_r3_svc_single : assert property (@(posedge clk) disable iff (!rst_n)
      svc_pulse |=> !svc_pulse);
   // R7: the incomplete flag only follows the end of a grant
   a_r7_partial_at_end : assert property (@(posedge clk) disable iff (!rst_n)
      partial_pulse |-> (!grant && $past(grant)));
endmodule

// File: rtl/ssa_byte_fifo.sv
`timescale 1ns/1ps
module ssa_byte_fifo #(
   parameter int DEPTH = 8,
   parameter int W     = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic [W-1:0] wdata,
   input  logic         rd_en,
   output logic [W-1:0] rdata,
   output logic         not_empty,
   output logic         full
);
   localparam int AW = $clog2(DEPTH);

   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] wr_ptr, rd_ptr;
   logic [AW:0]   cnt;
   logic          pop;

   assign not_empty = (cnt != '0);
   assign full      = (cnt == (AW+1)'(DEPTH));
   assign pop       = rd_en & not_empty;
   assign rdata     = mem[rd_ptr];

   always_ff @(posedge clk) begin
      if (push) mem[wr_ptr] <= wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         cnt    <= '0;
      end else begin
         if (push) wr_ptr <= wr_ptr + AW'(1);
         if (pop)  rd_ptr <= rd_ptr + AW'(1);
         case ({push, pop})
            2'b10:   cnt <= cnt + (AW+1)'(1);
            2'b01:   cnt <= cnt - (AW+1)'(1);
            default: cnt <= cnt;
         endcase
      end
   end

   // R8: the receiver never writes into a full queue
   a_r8_no_overflow : assert property (@(posedge clk) disable iff (!rst_n)
      push |-> !full);
   // R9: a read of an empty queue changes nothing
   a_r9_empty_read : assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && !not_empty && !push) |=> !not_empty);
endmodule

// File: rtl/ssa_tx_shift.sv
`timescale 1ns/1ps
module ssa_tx_shift
   import ssa_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   input  logic  rise_tick,
   input  logic  tx_valid,
   input  byte_t tx_data,
   output logic  tx_ready,
   output logic  txd
);
   logic [3:0] bits_left;
   byte_t      shreg;

   assign tx_ready = (bits_left == 4'd0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bits_left <= '0;
         shreg     <= '0;
         txd       <= 1'b1;
      end else if (tx_valid && tx_ready) begin
         shreg     <= tx_data;
         bits_left <= 4'(BYTE_W);
      end else if (rise_tick && !tx_ready) begin
         txd       <= shreg[BYTE_W-1];
         shreg     <= {shreg[BYTE_W-2:0], 1'b0};
         bits_left <= bits_left - 4'd1;
      end
   end

   // R10: the data line moves only together with a rising serial clock
   a_r10_txd_on_rise : assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(txd) |-> $past(rise_tick));
endmodule

// File: rtl/rtscts_serial_adapter.sv
`timescale 1ns/1ps
module rtscts_serial_adapter
   import ssa_pkg::*;
#(
   parameter int DIV_W       = 8,
   parameter int FIFO_DEPTH  = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [DIV_W-1:0] half_period,
   input  logic             rts_n_in,
   input  logic             rxd_in,
   output logic             src_txc_out,
   output logic             cts_n_out,
   output logic             svc_pulse,
   output logic             partial_pulse,
   input  logic             rd_en,
   output logic [7:0]       rd_data,
   output logic             rd_valid,
   input  logic             tx_valid,
   input  logic [7:0]       tx_data,
   output logic             tx_ready,
   output logic             txd_out,
   output logic             partner_rxc_out
);
   if (DIV_W < 3) begin : g_bad_div
      $error("DIV_W must be at least 3");
   end
   if (FIFO_DEPTH < 2 || (FIFO_DEPTH & (FIFO_DEPTH - 1)) != 0) begin : g_bad_depth
      $error("FIFO_DEPTH must be a power of two of at least 2");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   logic  sclk, rise_tick, fall_tick, fifo_full, push;
   byte_t push_data;

   ssa_sclk_gen #(.DIV_W(DIV_W)) u_sclk (
      .clk(clk), .rst_n(rst_n), .half_period(half_period),
      .sclk(sclk), .rise_tick(rise_tick), .fall_tick(fall_tick));

   ssa_rx_link #(.SYNC_STAGES(SYNC_STAGES)) u_rx (
      .clk(clk), .rst_n(rst_n), .rts_n_in(rts_n_in), .rxd_in(rxd_in),
      .rise_tick(rise_tick), .fall_tick(fall_tick), .fifo_full(fifo_full),
      .cts_n(cts_n_out), .svc_pulse(svc_pulse), .partial_pulse(partial_pulse),
      .push(push), .push_data(push_data));

   ssa_byte_fifo #(.DEPTH(FIFO_DEPTH), .W(BYTE_W)) u_fifo (
      .clk(clk), .rst_n(rst_n), .push(push), .wdata(push_data),
      .rd_en(rd_en), .rdata(rd_data), .not_empty(rd_valid), .full(fifo_full));

   ssa_tx_shift u_tx (
      .clk(clk), .rst_n(rst_n), .rise_tick(rise_tick), .tx_valid(tx_valid),
      .tx_data(tx_data), .tx_ready(tx_ready), .txd(txd_out));

   assign src_txc_out     = sclk;
   assign partner_rxc_out = ~sclk;
endmodule

// File: tb/rtscts_serial_adapter_tb_top.sv
`timescale 1ns/1ps
module rtscts_serial_adapter_tb_top;
   localparam int DW    = 8;
   localparam int DEPTH = 4;
   // each entry: {half period, byte}; expected read-back and transmit capture equal the byte
   localparam logic [15:0] VEC [6] = '{16'h04A5, 16'h033C, 16'h0580, 16'h0601,
                                       16'h07FF, 16'h0400};

   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic          rst_n = 1'b0;
   logic [DW-1:0] half_period = 8'd4;
   logic          rts_n_in = 1'b1, rxd_in = 1'b1, rd_en = 1'b0, tx_valid = 1'b0;
   logic [7:0]    tx_data = '0;
   logic          src_txc_out, cts_n_out, svc_pulse, partial_pulse, rd_valid;
   logic          tx_ready, txd_out, partner_rxc_out;
   logic [7:0]    rd_data;

   rtscts_serial_adapter #(.DIV_W(DW), .FIFO_DEPTH(DEPTH), .SYNC_STAGES(2)) dut_i (
      .clk(clk), .rst_n(rst_n), .half_period(half_period), .rts_n_in(rts_n_in),
      .rxd_in(rxd_in), .src_txc_out(src_txc_out), .cts_n_out(cts_n_out),
      .svc_pulse(svc_pulse), .partial_pulse(partial_pulse), .rd_en(rd_en),
      .rd_data(rd_data), .rd_valid(rd_valid), .tx_valid(tx_valid), .tx_data(tx_data),
      .tx_ready(tx_ready), .txd_out(txd_out), .partner_rxc_out(partner_rxc_out));

   int checks = 0, bad = 0, svc_cnt = 0, part_cnt = 0;

   always @(negedge clk) begin
      if (svc_pulse)     svc_cnt++;
      if (partial_pulse) part_cnt++;
   end

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wait_cts(input logic lvl, input int lim, output int n);
      n = 0;
      while (cts_n_out !== lvl && n < lim) begin
         @(negedge clk);
         n++;
      end
   endtask

   task automatic rx_bits(input logic [31:0] bits, input int n);
      int w;
      wait_cts(1'b0, 400, w);
      for (int i = 0; i < n; i++) begin
         @(negedge src_txc_out);
         #1 rxd_in = bits[n-1-i];
      end
   endtask

   task automatic rx_release();
      int w;
      @(negedge src_txc_out);
      #1 rts_n_in = 1'b1;
      wait_cts(1'b1, 40, w);
      chk(w <= 4, "R6 grant drop latency", 32'(w), 32'd4);
      repeat (4) @(negedge clk);
   endtask

   task automatic rx_send(input logic [31:0] bits, input int n);
      rts_n_in = 1'b0;
      rx_bits(bits, n);
      rx_release();
   endtask

   task automatic pop_chk(input logic [7:0] exp, input string req);
      @(negedge clk);
      chk(rd_valid === 1'b1 && rd_data === exp, req, {23'd0, rd_valid, rd_data}, {24'd1, exp});
      rd_en = 1'b1;
      @(negedge clk);
      rd_en = 1'b0;
   endtask

   task automatic tx_send(input logic [7:0] d, output logic [7:0] got);
      @(negedge clk);
      while (!tx_ready) @(negedge clk);
      tx_valid = 1'b1;
      tx_data  = d;
      @(negedge clk);
      tx_valid = 1'b0;
      chk(tx_ready === 1'b0, "R10 busy after accept", 32'(tx_ready), 32'd0);
      @(posedge src_txc_out);
      got = '0;
      for (int i = 0; i < 8; i++) begin
         @(posedge partner_rxc_out);
         got = {got[6:0], txd_out};
      end
   endtask

   task automatic measure(output int hi, output int lo, output bit inv_ok);
      inv_ok = 1'b1;
      @(posedge src_txc_out);
      @(negedge clk);
      hi = 0;
      while (src_txc_out == 1'b1 && hi < 300) begin
         hi++;
         if (partner_rxc_out !== ~src_txc_out) inv_ok = 1'b0;
         @(negedge clk);
      end
      lo = 0;
      while (src_txc_out == 1'b0 && lo < 300) begin
         lo++;
         if (partner_rxc_out !== ~src_txc_out) inv_ok = 1'b0;
         @(negedge clk);
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      bad++;
      $display("FAIL watchdog expired (all requirements) actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
   end

   initial begin
      int hi, lo, s0, p0, w;
      bit inv;
      logic [7:0] got, d;

      // R1: state during reset
      repeat (3) @(negedge clk);
      chk(cts_n_out === 1'b1 && rd_valid === 1'b0 && svc_pulse === 1'b0 &&
          partial_pulse === 1'b0 && src_txc_out === 1'b0 && txd_out === 1'b1 && tx_ready === 1'b1,
          "R1 reset outputs",
          {25'd0, cts_n_out, rd_valid, svc_pulse, partial_pulse, src_txc_out, txd_out, tx_ready},
          32'h43);
      rst_n = 1'b1;
      @(negedge clk);
      chk(cts_n_out === 1'b1 && rd_valid === 1'b0 && txd_out === 1'b1, "R1 after release",
          {29'd0, cts_n_out, rd_valid, txd_out}, 32'h5);

      // R4: data line activity without a request
      for (int i = 0; i < 100; i++) begin
         rxd_in = i[0];
         @(negedge clk);
         if (cts_n_out !== 1'b1) w = 1;
      end
      rxd_in = 1'b1;
      chk(cts_n_out === 1'b1 && rd_valid === 1'b0, "R4 no grant without request",
          {30'd0, cts_n_out, rd_valid}, 32'h2);

      // table walk: divider, single-byte receive, transmit
      p0 = part_cnt;
      for (int v = 0; v < 6; v++) begin
         half_period = VEC[v][15:8];
         d = VEC[v][7:0];
         repeat (40) @(negedge clk);
         measure(hi, lo, inv);
         chk(hi == int'(half_period), "R2 high phase", 32'(hi), 32'(half_period));
         chk(lo == int'(half_period), "R2 low phase", 32'(lo), 32'(half_period));
         chk(inv, "R2 partner clock inverted", 32'(inv), 32'd1);
         s0 = svc_cnt;
         rx_send({24'd0, d}, 8);
         chk(svc_cnt == s0 + 1, "R3 one service pulse", 32'(svc_cnt - s0), 32'd1);
         pop_chk(d, "R5 byte assembled MSB first");
         @(negedge clk);
         chk(rd_valid === 1'b0, "R9 empty after pop", 32'(rd_valid), 32'd0);
         tx_send(d, got);
         chk(got === d, "R10 transmitted byte", 32'(got), 32'(d));
      end
      chk(part_cnt == p0, "R7 no flag on whole bytes", 32'(part_cnt - p0), 32'd0);

      // R2: clamp of a too-small setting
      half_period = 8'd1;
      repeat (20) @(negedge clk);
      measure(hi, lo, inv);
      chk(hi == 3 && lo == 3, "R2 clamp to three", {hi[15:0], lo[15:0]}, 32'h00030003);

      // R7: request ends three bits into the second byte
      half_period = 8'd4;
      p0 = part_cnt;
      rx_send({21'd0, 8'hC3, 3'b101}, 11);
      chk(part_cnt == p0 + 1, "R7 incomplete flag", 32'(part_cnt - p0), 32'd1);
      pop_chk(8'hC3, "R7 whole byte kept");
      @(negedge clk);
      chk(rd_valid === 1'b0, "R7 partial bits dropped", 32'(rd_valid), 32'd0);

      // R8: full queue holds back the grant
      rx_send(32'h11223344, 32);
      chk(rd_valid === 1'b1, "R9 queue filled", 32'(rd_valid), 32'd1);
      s0 = svc_cnt;
      rts_n_in = 1'b0;
      repeat (60) @(negedge clk);
      chk(cts_n_out === 1'b1, "R8 grant withheld when full", 32'(cts_n_out), 32'd1);
      chk(svc_cnt == s0 + 1, "R3 service pulse while full", 32'(svc_cnt - s0), 32'd1);
      pop_chk(8'h11, "R9 oldest first");
      wait_cts(1'b0, 20, w);
      chk(cts_n_out === 1'b0 && w <= 6, "R8 grant after space frees", {w[15:0], 15'd0, cts_n_out}, 32'd0);
      rx_bits(32'h55, 8);
      rx_release();
      pop_chk(8'h22, "R9 order second");
      pop_chk(8'h33, "R9 order third");
      pop_chk(8'h44, "R9 order fourth");
      pop_chk(8'h55, "R8 byte after regrant");
      @(negedge clk);
      chk(rd_valid === 1'b0, "R9 drained", 32'(rd_valid), 32'd0);

      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
   end
endmodule